// File: doc/BRIEF.md
# Egress Cell Resequencing Window

This block sits at an egress port of a multi-path packet fabric. Cells from several source flows arrive here out of order, because each cell may take a different path through the fabric. Every cell carries a flow number, a sequence number and a payload tag. The block stores the tag in that flow's window at the slot named by the sequence number. It releases cells toward the reassembly stage only in strict sequence order per flow. At most one cell leaves per cycle, and flows that hold a releasable cell take turns.

Each flow has an expected-sequence pointer. A cell leaves only when the slot under that pointer is filled, and the pointer then steps forward by one and wraps at the window size. A periodic acknowledgment generator visits the flows one after another. For each flow it reports the current expected pointer to the sender side, so that the sender can bound its outstanding cells to the window. Acknowledgments wait in a small buffer behind a valid/ready handshake. When that buffer is full, generation pauses and nothing is lost.

Top module: `cell_reorder_buf`

## Requirements
- R1: A cell written as (flow f, sequence s, tag t) is later emitted with out_flow=f, out_seq=s and out_tag=t. For each flow, cells are emitted in increasing sequence order, and that order wraps modulo WIN (WIN is a power of two).
- R2: No cell of a flow is emitted while a slot with an earlier expected sequence number of that flow is still empty.
- R3: Each emission advances that flow's expected pointer by one. The pointer returns from WIN-1 to 0, so after the wrap, sequence 0 is accepted and emitted again.
- R4: At most one cell is emitted per cycle. When several flows hold a releasable cell, grants rotate round-robin starting after the last granted flow, and no cycle is left idle while any flow is releasable.
- R5: A slot is marked empty when its cell is emitted, so the same slot can be filled again once the sequence numbers wrap.
- R6: A write to a slot that is already occupied is dropped: the stored tag is kept. dup_err is high for exactly the one cycle after that write edge.
- R7: Every ACK_PERIOD cycles, one acknowledgment is generated. Generation visits flows 0,1,…,NUM_FLOWS-1 and then starts over. Each acknowledgment carries the flow number and that flow's expected pointer at the moment of generation.
- R8: Acknowledgments wait in a buffer of ACK_DEPTH entries. While ack_valid is high and ack_ready is low, ack_valid, ack_flow and ack_ptr do not change.
- R9: When the acknowledgment buffer is full, the period counter stops at its terminal count. Generation resumes with the next flow in turn as soon as space frees, so no acknowledgment is skipped.
- R10: After reset all slots are empty, all pointers are 0, and out_valid, dup_err and ack_valid are low.
- R11: A cell written into the slot under its flow's expected pointer appears on the output one cycle after its write edge, if no other flow is competing for the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is present this cycle |
| in_flow | input | FLOW_W | Source flow of the arriving cell |
| in_seq | input | SEQ_W | Sequence number of the arriving cell |
| in_tag | input | TAG_W | Payload tag of the arriving cell |
| out_valid | output | 1 | An in-order cell is emitted this cycle |
| out_flow | output | FLOW_W | Flow of the emitted cell |
| out_seq | output | SEQ_W | Sequence number of the emitted cell |
| out_tag | output | TAG_W | Payload tag of the emitted cell |
| dup_err | output | 1 | Pulse: the previous write hit an occupied slot |
| ack_valid | output | 1 | An acknowledgment is offered |
| ack_ready | input | 1 | The acknowledgment is taken this cycle |
| ack_flow | output | FLOW_W | Flow the acknowledgment refers to |
| ack_ptr | output | SEQ_W | Expected pointer of that flow |

## Verification
The bench builds the block with a window of 8, four flows, an acknowledgment period of 8 and an acknowledgment buffer of only 2 entries. The short window lets a flow run through every sequence number and wrap back to slot 0 within a few dozen cycles. The two-entry buffer fills after two periods once ack_ready is held low, which brings the stall-and-resume path and the handshake hold into a short run. Four flows are enough to see the round-robin grants alternate between two backlogged flows, and to see the acknowledgment generator visit every flow in turn.

// File: rtl/reseq_pkg.sv
package reseq_pkg;

  // Modular increment used for sequence pointers and ring indices.
  function automatic int wrap_inc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/reseq_flow_win.sv
module reseq_flow_win
  import reseq_pkg::*;
#(
  parameter int WIN   = 256,
  parameter int TAG_W = 8,
  localparam int SEQ_W = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             rel_en,
  output logic             head_rdy,
  output logic [TAG_W-1:0] head_tag,
  output logic [SEQ_W-1:0] exp_ptr,
  output logic             wr_dup
);

  logic [WIN-1:0]   slot_vld;
  logic [TAG_W-1:0] slot_tag [WIN];
  logic [SEQ_W-1:0] exp_q;
  logic             wr_take;

  assign head_rdy = slot_vld[exp_q];
  assign head_tag = slot_tag[exp_q];
  assign exp_ptr  = exp_q;
  assign wr_dup   = wr_en && slot_vld[wr_seq];
  assign wr_take  = wr_en && !slot_vld[wr_seq];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld <= '0;
      exp_q    <= '0;
    end else begin
      if (rel_en) begin
        slot_vld[exp_q] <= 1'b0;
        exp_q           <= SEQ_W'(wrap_inc(int'(exp_q), WIN));
      end
      if (wr_take) slot_vld[wr_seq] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) slot_tag[wr_seq] <= wr_tag;
  end

  // R2: a release is only granted while the head slot is filled
  assert_head_filled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> head_rdy);

  // R3: pointer moves by exactly one per release, wrapping at WIN-1
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> (($past(exp_q) == SEQ_W'(WIN-1)) ? (exp_q == '0) : (exp_q == $past(exp_q) + 1'b1)));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_en |=> $stable(exp_q));

  // R5: the released slot is empty afterwards
  assert_slot_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> !slot_vld[$past(exp_q)]);

  // R6: a duplicate write leaves the stored tag untouched
  assert_dup_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dup |=> slot_tag[$past(wr_seq)] == $past(slot_tag[wr_seq]));

endmodule

// File: rtl/reseq_rr_arb.sv
module reseq_rr_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);

  logic [IW-1:0] last_q;

  function automatic logic [IW-1:0] rot(input logic [IW-1:0] base, input int k);
    return IW'((int'(base) + k) % N);
  endfunction

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!gnt_any && req[rot(last_q, k)]) begin
        gnt_any             = 1'b1;
        gnt_idx             = rot(last_q, k);
        gnt[rot(last_q, k)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end

  // R4: a single grant per cycle, and no idle cycle while anyone asks
  assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_work_conserving_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

  assert_grant_has_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/reseq_ack_gen.sv
module reseq_ack_gen
  import reseq_pkg::*;
#(
  parameter int N      = 4,
  parameter int SEQ_W  = 8,
  parameter int PERIOD = 8,
  parameter int DEPTH  = 4,
  localparam int IW = $clog2(N),
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1),
  localparam int EW = IW + SEQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEQ_W-1:0] exp_in [N],
  input  logic             ack_ready,
  output logic             ack_valid,
  output logic [IW-1:0]    ack_flow,
  output logic [SEQ_W-1:0] ack_ptr
);

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] turn_q;
  logic [EW-1:0] fifo [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [NW-1:0] fill_q;
  logic          tick, full, push, pop;

  assign tick      = (cnt_q == CW'(PERIOD - 1));
  assign full      = (fill_q == NW'(DEPTH));
  assign push      = tick && !full;
  assign ack_valid = (fill_q != '0);
  assign pop       = ack_valid && ack_ready;
  assign {ack_flow, ack_ptr} = fifo[rp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      turn_q <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (!tick)     cnt_q <= cnt_q + 1'b1;
      else if (push) cnt_q <= '0;
      if (push) begin
        turn_q <= IW'(wrap_inc(int'(turn_q), N));
        wp_q   <= PW'(wrap_inc(int'(wp_q), DEPTH));
      end
      if (pop) rp_q <= PW'(wrap_inc(int'(rp_q), DEPTH));
      if (push && !pop)      fill_q <= fill_q + 1'b1;
      else if (pop && !push) fill_q <= fill_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp_q] <= {turn_q, exp_in[turn_q]};
  end

  // R8: an offered acknowledgment is held until taken
  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_flow) && $stable(ack_ptr)));

  // R9: the buffer never exceeds its depth, and a full buffer freezes the period counter
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= NW'(DEPTH));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && full) |=> (tick && $stable(turn_q)));

endmodule

// File: rtl/cell_reorder_buf.sv
module cell_reorder_buf #(
  parameter int NUM_FLOWS  = 4,
  parameter int WIN        = 256,
  parameter int TAG_W      = 8,
  parameter int ACK_PERIOD = 8,
  parameter int ACK_DEPTH  = 4,
  localparam int FLOW_W = $clog2(NUM_FLOWS),
  localparam int SEQ_W  = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [FLOW_W-1:0] out_flow,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [TAG_W-1:0]  out_tag,
  output logic              dup_err,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic [FLOW_W-1:0] ack_flow,
  output logic [SEQ_W-1:0]  ack_ptr
);

  logic [NUM_FLOWS-1:0] ready_v, gnt_v, dup_v;
  logic [SEQ_W-1:0]     exp_v [NUM_FLOWS];
  logic [TAG_W-1:0]     tag_v [NUM_FLOWS];
  logic [FLOW_W-1:0]    gnt_idx;
  logic                 gnt_any;

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    reseq_flow_win #(.WIN(WIN), .TAG_W(TAG_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (in_valid && (in_flow == FLOW_W'(f))),
      .wr_seq   (in_seq),
      .wr_tag   (in_tag),
      .rel_en   (gnt_v[f]),
      .head_rdy (ready_v[f]),
      .head_tag (tag_v[f]),
      .exp_ptr  (exp_v[f]),
      .wr_dup   (dup_v[f])
    );
  end

  reseq_rr_arb #(.N(NUM_FLOWS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (ready_v),
    .gnt     (gnt_v),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  reseq_ack_gen #(.N(NUM_FLOWS), .SEQ_W(SEQ_W), .PERIOD(ACK_PERIOD), .DEPTH(ACK_DEPTH)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .exp_in    (exp_v),
    .ack_ready (ack_ready),
    .ack_valid (ack_valid),
    .ack_flow  (ack_flow),
    .ack_ptr   (ack_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flow  <= '0;
      out_seq   <= '0;
      out_tag   <= '0;
      dup_err   <= 1'b0;
    end else begin
      out_valid <= gnt_any;
      dup_err   <= |dup_v;
      if (gnt_any) begin
        out_flow <= gnt_idx;
        out_seq  <= exp_v[gnt_idx];
        out_tag  <= tag_v[gnt_idx];
      end
    end
  end

  // R6: a write into an occupied slot is flagged on the following cycle
  assert_dup_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|dup_v)) |=> dup_err);

  // R11: a filled head slot for a lone requester reaches the output next cycle
  assert_head_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ready_v) |=> out_valid);

endmodule

// File: tb/sim_cell_reorder_buf.sv
`timescale 1ns/1ps
module sim_cell_reorder_buf;

  localparam int NF = 4, WIN = 8, TW = 8, PER = 8, DEP = 2;
  localparam int FW = 2, SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [FW-1:0] in_flow = '0;
  logic [SW-1:0] in_seq = '0;
  logic [TW-1:0] in_tag = '0;
  logic ack_ready = 1'b1;
  logic out_valid, dup_err, ack_valid;
  logic [FW-1:0] out_flow, ack_flow;
  logic [SW-1:0] out_seq, ack_ptr;
  logic [TW-1:0] out_tag;

  always #2.5 clk = ~clk;

  cell_reorder_buf #(.NUM_FLOWS(NF), .WIN(WIN), .TAG_W(TW), .ACK_PERIOD(PER), .ACK_DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flow(in_flow), .in_seq(in_seq),
    .in_tag(in_tag), .out_valid(out_valid), .out_flow(out_flow), .out_seq(out_seq),
    .out_tag(out_tag), .dup_err(dup_err), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_flow(ack_flow), .ack_ptr(ack_ptr));

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Output log sampled between edges
  logic log_en = 1'b0;
  int   n_log = 0;
  int   lg_f [32];
  int   lg_s [32];
  int   lg_t [32];
  always @(negedge clk) begin
    if (log_en && out_valid && n_log < 32) begin
      lg_f[n_log] = int'(out_flow);
      lg_s[n_log] = int'(out_seq);
      lg_t[n_log] = int'(out_tag);
      n_log++;
    end
  end

  task automatic cyc(input logic v, input int f, input int s, input int t);
    @(negedge clk);
    in_valid = v;
    in_flow  = FW'(f);
    in_seq   = SW'(s);
    in_tag   = TW'(t);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic       iv;
    logic [1:0] fl;
    logic [2:0] sq;
    logic [7:0] tg;
    logic       ov;
    logic [1:0] ofl;
    logic [2:0] osq;
    logic [7:0] otg;
  } vec_t;

  // Each row: cell driven before an edge, output expected just after that edge (R1, R2, R11)
  localparam vec_t TBL [10] = '{
    '{1'b1, 2'd0, 3'd2, 8'h12, 1'b0, 2'd0, 3'd0, 8'h00},
    '{1'b1, 2'd0, 3'd1, 8'h11, 1'b0, 2'd0, 3'd0, 8'h00},
    '{1'b1, 2'd0, 3'd0, 8'h10, 1'b0, 2'd0, 3'd0, 8'h00},
    '{1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd0, 8'h10},
    '{1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd1, 8'h11},
    '{1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd2, 8'h12},
    '{1'b1, 2'd1, 3'd0, 8'h20, 1'b0, 2'd0, 3'd0, 8'h00},
    '{1'b1, 2'd1, 3'd1, 8'h21, 1'b1, 2'd1, 3'd0, 8'h20},
    '{1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2'd1, 3'd1, 8'h21},
    '{1'b0, 2'd0, 3'd0, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00}
  };

  initial begin
    #(5.0 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ack_cyc [5];
    int ack_fl  [5];
    int ack_pt  [5];
    int na;
    do_reset();
    #1;
    // R10 reset state
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 dup_err", int'(dup_err), 0);
    chk("R10 ack_valid", int'(ack_valid), 0);

    // Table walk: R1 R2 R11
    foreach (TBL[i]) begin
      cyc(TBL[i].iv, int'(TBL[i].fl), int'(TBL[i].sq), int'(TBL[i].tg));
      chk($sformatf("R1/R2/R11 row%0d out_valid", i), int'(out_valid), int'(TBL[i].ov));
      if (TBL[i].ov) begin
        chk($sformatf("R1 row%0d flow", i), int'(out_flow), int'(TBL[i].ofl));
        chk($sformatf("R1 row%0d seq", i), int'(out_seq), int'(TBL[i].osq));
        chk($sformatf("R1 row%0d tag", i), int'(out_tag), int'(TBL[i].otg));
      end
    end

    // R6 duplicate write on flow 2, slot 3
    cyc(1'b1, 2, 3, 'hAA);
    chk("R6 no flag on first write", int'(dup_err), 0);
    cyc(1'b1, 2, 3, 'hBB);
    chk("R6 flag after duplicate", int'(dup_err), 1);
    cyc(1'b0, 0, 0, 0);
    chk("R6 flag is one cycle", int'(dup_err), 0);
    n_log = 0;
    log_en = 1'b1;
    cyc(1'b1, 2, 0, 'h30);
    cyc(1'b1, 2, 1, 'h31);
    cyc(1'b1, 2, 2, 'h32);
    idle(5);
    log_en = 1'b0;
    chk("R6 emitted count", n_log, 4);
    chk("R6 slot3 seq", lg_s[3], 3);
    chk("R6 first tag kept", lg_t[3], 'hAA);

    // R3 R5 wrap on flow 3
    n_log = 0;
    log_en = 1'b1;
    for (int s = 0; s < WIN; s++) cyc(1'b1, 3, s, 'h40 + s);
    idle(2);
    cyc(1'b1, 3, 0, 'h50);
    idle(3);
    log_en = 1'b0;
    chk("R3 emitted count incl wrap", n_log, WIN + 1);
    for (int k = 0; k < WIN; k++) chk("R3 seq order", lg_s[k], k);
    chk("R3 wrapped seq", lg_s[WIN], 0);
    chk("R5 reused slot tag", lg_t[WIN], 'h50);

    // R4 round robin: flow 0 expects 3, flow 1 expects 2
    n_log = 0;
    log_en = 1'b1;
    cyc(1'b1, 0, 4, 'h04);
    cyc(1'b1, 0, 5, 'h05);
    cyc(1'b1, 0, 6, 'h06);
    cyc(1'b1, 1, 3, 'h13);
    cyc(1'b1, 1, 4, 'h14);
    cyc(1'b1, 1, 5, 'h15);
    chk("R2 nothing released with gaps", n_log, 0);
    cyc(1'b1, 0, 3, 'h03);
    cyc(1'b1, 1, 2, 'h12);
    idle(10);
    log_en = 1'b0;
    chk("R4 emitted count", n_log, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R4 alternating flow", lg_f[k], k % 2);
      chk("R4 per-flow order", lg_s[k], (k % 2 == 0) ? 3 + k / 2 : 2 + k / 2);
    end

    // R7 acknowledgment period, rotation and content
    ack_ready = 1'b1;
    do_reset();
    cyc(1'b1, 1, 0, 'h70);
    cyc(1'b1, 1, 1, 'h71);
    in_valid = 1'b0;
    na = 0;
    for (int c = 0; c < 60 && na < 5; c++) begin
      @(posedge clk);
      #1;
      if (ack_valid) begin
        ack_cyc[na] = c;
        ack_fl[na]  = int'(ack_flow);
        ack_pt[na]  = int'(ack_ptr);
        na++;
      end
    end
    chk("R7 acks seen", na, 5);
    for (int k = 1; k < 5; k++) chk("R7 period", ack_cyc[k] - ack_cyc[k-1], PER);
    for (int k = 0; k < 5; k++) chk("R7 flow turn", ack_fl[k], k % NF);
    chk("R7 flow1 ptr", ack_pt[1], 2);
    chk("R7 flow0 ptr", ack_pt[0], 0);

    // R8 R9 full buffer stalls, then resumes without skipping a flow
    ack_ready = 1'b0;
    do_reset();
    idle(40);
    chk("R9 ack offered", int'(ack_valid), 1);
    chk("R8 head flow0", int'(ack_flow), 0);
    idle(3);
    chk("R8 head held", int'(ack_flow), 0);
    chk("R8 valid held", int'(ack_valid), 1);
    @(negedge clk);
    ack_ready = 1'b1;
    @(posedge clk);
    #1;
    ack_ready = 1'b0;
    @(negedge clk);
    chk("R9 second entry flow1", int'(ack_flow), 1);
    ack_ready = 1'b1;
    @(posedge clk);
    #1;
    ack_ready = 1'b0;
    @(negedge clk);
    chk("R9 resumed with flow2", int'(ack_flow), 2);
    chk("R9 valid after resume", int'(ack_valid), 1);
    ack_ready = 1'b1;
    @(posedge clk);
    #1;
    ack_ready = 1'b0;
    for (int c = 0; c < 20 && !ack_valid; c++) begin
      @(posedge clk);
      #1;
    end
    chk("R9 next flow3", int'(ack_flow), 3);
    chk("R9 flow3 ptr", int'(ack_ptr), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule